// File: doc/BRIEF.md
# Byte-Padded Inference Frame Adapter

This block connects a host bus (8-bit data in each direction, 16-bit byte address, separate read and write strobes) to a streaming compute network. The host loads a complete input frame as bytes. Each logical sample takes the fewest whole bytes that hold its width, with the low byte first. The host then writes a control address to start a run. The block unpacks every sample to its native width and streams the frame into the network at one sample per clock. It stores the first output samples the network returns, keeping each one at its native width. The host reads those results back as zero-padded, little-endian bytes.

A busy flag covers the whole run, from the start command until the last result has been stored. While busy is high, host writes are dropped. Reads are served at all times, and a 16-byte design identifier can always be read at a fixed high address. A synchronous reset returns the block to idle.

The byte address map depends on the parameters. With `IB = ceil(IN_W/8)` and `OB = ceil(OUT_W/8)`:
- The input frame starts at byte 0 and is `IN_N*IB` bytes long.
- The result area starts at byte `IN_N*IB` and is `OUT_N*OB` bytes long.
- The start command is at address 0xFFE0.
- The identifier occupies 0xFFF0 to 0xFFFF.

Top module: `frame_adapter`

## Requirements
- R1: Input sample j occupies bytes j*IB to j*IB+IB-1 of the input area, starting at address 0. Byte k of a sample holds sample bits 8k+7 down to 8k, so the low byte comes first.
- R2: A write to the input area while idle stores the byte. A read strobe at any address updates host_rdata at the next clock edge, and an input-area read returns the byte exactly as it was written, pad bits included. With no read strobe, host_rdata holds its value.
- R3: A write of any data to address 0xFFE0 while idle starts a run, and busy is high after the next clock edge.
- R4: A run asserts net_in_valid for exactly IN_N consecutive cycles. These cycles present samples 0 to IN_N-1 in order on net_in_data, using only the low IN_W bits of each padded sample, so the pad bits have no effect.
- R5: During a run, the first OUT_N cycles with net_out_valid high are stored in order as results 0 to OUT_N-1. Later valid outputs in the same run are not stored.
- R6: Result j is read at byte address IN_N*IB + j*OB + k for byte k, low byte first. Bits above OUT_W read as zero.
- R7: busy stays high until all IN_N samples have been fed and all OUT_N results have been stored. net_in_valid is never high while busy is low.
- R8: Host writes made while busy are ignored. This applies to writes to input bytes and to writes to the start address.
- R9: A read of address 0xFFF0+k returns byte k of the 128-bit design identifier 0x3C91A7E25B04D86F12C39E7A40B5F618, where byte k is bits 8k+7 down to 8k.
- R10: A read of any address outside the input area, the result area and the identifier returns 0. This includes the start address.
- R11: After reset, busy, net_in_valid and host_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| busy | output | 1 | Run in progress |
| net_in_valid | output | 1 | Sample valid towards the network |
| net_in_data | output | IN_W | Unpacked input sample |
| net_out_valid | input | 1 | Network result valid |
| net_out_data | input | OUT_W | Network result sample |

## Verification
The assertions check several properties on every cycle:
- A start command always raises busy.
- Once started, the feed runs without gaps and with incrementing indices.
- The result count never passes OUT_N.
- busy falls only when the result store is full.
- host_rdata does not change without a read strobe.

Only the bench scenarios can show that the values are correct. This covers byte placement inside padded samples, pad bits being ignored on unpacking, capture of the first OUT_N network outputs and no later ones, dropped writes during a run, and the identifier and unmapped read values.

// File: rtl/frame_adapter_pkg.sv
package frame_adapter_pkg;

    function automatic int bytes_for(input int width);
        return (width + 7) / 8;
    endfunction

    localparam logic [15:0]  CTRL_ADDR = 16'hFFE0;
    localparam logic [15:0]  ID_BASE   = 16'hFFF0;
    localparam logic [127:0] DESIGN_ID = 128'h3C91_A7E2_5B04_D86F_12C3_9E7A_40B5_F618;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FEED,
        ST_DRAIN
    } run_state_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
    } host_req_t;

endpackage

// File: rtl/fa_in_frame.sv
module fa_in_frame #(
    parameter int IN_W = 12,
    parameter int IN_N = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [15:0]     wr_addr,
    input  logic [7:0]      wr_byte,
    input  logic [15:0]     rd_addr,
    output logic [7:0]      rd_byte,
    input  logic [$clog2(IN_N)-1:0] smp_idx,
    output logic [IN_W-1:0] smp
);
    localparam int          IB   = frame_adapter_pkg::bytes_for(IN_W);
    localparam int          SIW  = $clog2(IN_N);
    localparam logic [15:0] IB16 = 16'(IB);

    logic [IN_N-1:0][IB*8-1:0] mem;
    logic [15:0] ws, wb, rs, rb;

    assign ws = wr_addr / IB16;
    assign wb = wr_addr % IB16;
    assign rs = rd_addr / IB16;
    assign rb = rd_addr % IB16;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[ws[SIW-1:0]][int'(wb)*8 +: 8] <= wr_byte;
        end
    end

    assign rd_byte = mem[rs[SIW-1:0]][int'(rb)*8 +: 8];
    assign smp     = mem[smp_idx][IN_W-1:0];
endmodule

// File: rtl/fa_out_store.sv
module fa_out_store #(
    parameter int OUT_W = 10,
    parameter int OUT_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             cap_en,
    input  logic             res_valid,
    input  logic [OUT_W-1:0] res_data,
    output logic             full,
    input  logic [15:0]      rd_rel,
    output logic [7:0]       rd_byte
);
    localparam int          OB   = frame_adapter_pkg::bytes_for(OUT_W);
    localparam int          OIW  = $clog2(OUT_N);
    localparam int          CW   = $clog2(OUT_N + 1);
    localparam logic [15:0] OB16 = 16'(OB);

    logic [OUT_N-1:0][OUT_W-1:0] mem;
    logic [CW-1:0]               cnt;
    logic [15:0]                 rs, rb;
    logic [OB*8-1:0]             padded;

    assign full = (cnt == CW'(OUT_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mem <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (cap_en && res_valid && !full) begin
            mem[cnt[OIW-1:0]] <= res_data;
            cnt               <= cnt + 1'b1;
        end
    end

    assign rs = rd_rel / OB16;
    assign rb = rd_rel % OB16;

    always_comb begin
        padded             = '0;
        padded[OUT_W-1:0]  = mem[rs[OIW-1:0]];
        rd_byte            = padded[int'(rb)*8 +: 8];
    end

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(OUT_N));
endmodule

// File: rtl/fa_run_seq.sv
module fa_run_seq #(
    parameter int IN_N = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cap_full,
    output logic                    busy,
    output logic                    feed_valid,
    output logic [$clog2(IN_N)-1:0] feed_idx
);
    import frame_adapter_pkg::*;
    localparam int SIW = $clog2(IN_N);
    localparam logic [SIW-1:0] LAST = SIW'(IN_N - 1);

    run_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            feed_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_FEED;
                    feed_idx <= '0;
                end
                ST_FEED: begin
                    if (feed_idx == LAST) state <= ST_DRAIN;
                    else                  feed_idx <= feed_idx + 1'b1;
                end
                ST_DRAIN: if (cap_full) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign feed_valid = (state == ST_FEED);

    a_r4_feed_contiguous: assert property (@(posedge clk) disable iff (rst)
        (feed_valid && feed_idx != LAST) |=> (feed_valid && feed_idx == $past(feed_idx) + 1'b1));
endmodule

// File: rtl/frame_adapter.sv
module frame_adapter #(
    parameter int IN_W  = 12,
    parameter int IN_N  = 6,
    parameter int OUT_W = 10,
    parameter int OUT_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [15:0]      host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             busy,
    output logic             net_in_valid,
    output logic [IN_W-1:0]  net_in_data,
    input  logic             net_out_valid,
    input  logic [OUT_W-1:0] net_out_data
);
    import frame_adapter_pkg::*;
    localparam int          IB        = bytes_for(IN_W);
    localparam int          OB        = bytes_for(OUT_W);
    localparam logic [15:0] IN_BYTES  = 16'(IN_N * IB);
    localparam logic [15:0] OUT_BASE  = IN_BYTES;
    localparam logic [15:0] OUT_END   = 16'(IN_N * IB + OUT_N * OB);

    host_req_t req;
    logic [$clog2(IN_N)-1:0] feed_idx;
    logic       start, wr_in, cap_full;
    logic [7:0] in_byte, out_byte;
    logic [15:0] out_rel, id_rel;

    assign req     = '{rd: host_rd, wr: host_wr, addr: host_addr, data: host_wdata};
    assign wr_in   = req.wr && !busy && (req.addr < IN_BYTES);
    assign start   = req.wr && !busy && (req.addr == CTRL_ADDR);
    assign out_rel = req.addr - OUT_BASE;
    assign id_rel  = req.addr - ID_BASE;

    fa_in_frame #(.IN_W(IN_W), .IN_N(IN_N)) u_in (
        .clk(clk), .rst(rst), .wr_en(wr_in), .wr_addr(req.addr), .wr_byte(req.data),
        .rd_addr(req.addr), .rd_byte(in_byte), .smp_idx(feed_idx), .smp(net_in_data)
    );

    fa_out_store #(.OUT_W(OUT_W), .OUT_N(OUT_N)) u_out (
        .clk(clk), .rst(rst), .clear(start), .cap_en(busy),
        .res_valid(net_out_valid), .res_data(net_out_data), .full(cap_full),
        .rd_rel(out_rel), .rd_byte(out_byte)
    );

    fa_run_seq #(.IN_N(IN_N)) u_seq (
        .clk(clk), .rst(rst), .start(start), .cap_full(cap_full),
        .busy(busy), .feed_valid(net_in_valid), .feed_idx(feed_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (req.rd) begin
            if (req.addr < IN_BYTES)
                host_rdata <= in_byte;
            else if (req.addr < OUT_END)
                host_rdata <= out_byte;
            else if (req.addr >= ID_BASE)
                host_rdata <= DESIGN_ID[int'(id_rel[3:0])*8 +: 8];
            else
                host_rdata <= '0;
        end
    end

    a_r3_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    a_r7_idle_only_when_full: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> cap_full);
    a_r7_no_feed_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !net_in_valid);
    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/frame_adapter_bench.sv
module frame_adapter_bench;
    localparam int IN_W = 12, IN_N = 6, OUT_W = 10, OUT_N = 4;
    localparam int IB = (IN_W + 7) / 8, OB = (OUT_W + 7) / 8;
    localparam int OUT_BASE = IN_N * IB;
    localparam logic [127:0] ID_EXP = 128'h3C91A7E25B04D86F12C39E7A40B5F618;

    logic clk = 0, rst = 1;
    logic host_rd = 0, host_wr = 0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0, host_rdata;
    logic busy, net_in_valid, net_out_valid;
    logic [IN_W-1:0]  net_in_data;
    logic [OUT_W-1:0] net_out_data;

    int checks = 0, errors = 0;
    int smp [IN_N];
    int mon_cnt = 0, mon_bursts = 0, mon_bad = 0, mon_idle_feed = 0;
    logic prev_v = 0;

    always #10 clk = ~clk;

    frame_adapter #(.IN_W(IN_W), .IN_N(IN_N), .OUT_W(OUT_W), .OUT_N(OUT_N)) u_frame_adapter (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .net_in_valid(net_in_valid), .net_in_data(net_in_data),
        .net_out_valid(net_out_valid), .net_out_data(net_out_data)
    );

    // Network stand-in: two-stage shift register computing 3*x+1
    logic             v1, v2;
    logic [OUT_W-1:0] d1, d2;
    always_ff @(posedge clk) begin
        v1 <= net_in_valid && !rst;
        d1 <= OUT_W'(32'(net_in_data) * 3 + 1);
        v2 <= v1 && !rst;
        d2 <= d1;
    end
    assign net_out_valid = v2;
    assign net_out_data  = d2;

    function automatic int fnet(input int x);
        return (x * 3 + 1) & ((1 << OUT_W) - 1);
    endfunction

    always @(negedge clk) begin
        if (net_in_valid) begin
            if (!busy) mon_idle_feed++;
            if (!prev_v) mon_bursts++;
            if (mon_cnt < IN_N && int'(net_in_data) != smp[mon_cnt]) mon_bad++;
            mon_cnt++;
        end
        prev_v = net_in_valid;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input int a, input int d);
        @(negedge clk);
        host_wr = 1; host_addr = 16'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(input int a, output int d);
        @(negedge clk);
        host_rd = 1; host_addr = 16'(a);
        @(negedge clk);
        host_rd = 0;
        d = int'(host_rdata);
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 1000 && busy; t++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rv, junk;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R11 busy after reset", int'(busy), 0);
        check("R11 net_in_valid after reset", int'(net_in_valid), 0);
        check("R11 rdata after reset", int'(host_rdata), 0);

        for (int p = 0; p < 3; p++) begin
            junk = (p == 1) ? 8'hF0 : 0;
            for (int j = 0; j < IN_N; j++) begin
                if (p == 0) smp[j] = (j * 32'h111 + 1) & 12'hFFF;
                else if (p == 1) smp[j] = 12'hFFF - j;
                else smp[j] = ((j + 5) * 2654435 + 77) & 12'hFFF;
            end
            // R1: little-endian byte placement, pad bits junk in pattern 1
            for (int j = 0; j < IN_N; j++)
                for (int k = 0; k < IB; k++)
                    hwrite(j * IB + k, ((smp[j] >> (8 * k)) | ((k == IB - 1) ? junk : 0)) & 8'hFF);
            for (int j = 0; j < IN_N; j++)
                for (int k = 0; k < IB; k++) begin
                    hread(j * IB + k, rv);
                    check("R2 R1 input readback", rv, ((smp[j] >> (8 * k)) | ((k == IB - 1) ? junk : 0)) & 8'hFF);
                end
            mon_cnt = 0; mon_bursts = 0; mon_bad = 0;
            hwrite(16'hFFE0, p);
            check("R3 busy after start", int'(busy), 1);
            wait_idle();
            check("R4 feed count", mon_cnt, IN_N);
            check("R4 single burst", mon_bursts, 1);
            check("R4 feed data and pad ignored", mon_bad, 0);
            check("R7 no feed while idle", mon_idle_feed, 0);
            for (int j = 0; j < OUT_N; j++)
                for (int k = 0; k < OB; k++) begin
                    hread(OUT_BASE + j * OB + k, rv);
                    check("R5 R6 R7 result byte", rv, (fnet(smp[j]) >> (8 * k)) & 8'hFF);
                end
        end

        // R8: writes during a run are dropped
        hread(0, junk);
        hwrite(16'hFFE0, 0);
        hwrite(0, junk ^ 8'h5A);
        hwrite(16'hFFE0, 0);
        wait_idle();
        hread(0, rv);
        check("R8 input write while busy ignored", rv, junk);
        repeat (5) @(negedge clk);
        check("R8 start while busy ignored", int'(busy), 0);

        for (int k = 0; k < 16; k++) begin
            hread(16'hFFF0 + k, rv);
            check("R9 identifier byte", rv, int'(ID_EXP[k*8 +: 8]));
        end
        hread(16'h8000, rv);
        check("R10 unmapped read", rv, 0);
        hread(16'hFFE0, rv);
        check("R10 control address read", rv, 0);
        hread(OUT_BASE + OUT_N * OB, rv);
        check("R10 read past results", rv, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule